// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block is the digital control for a 14-bit successive-approximation converter. It runs on a clock at twice the master-clock rate, so every half master-clock period is one cycle. It also produces the master clock itself. A conversion is requested in one of two ways: a rising edge on a start pin, or a control-register write strobe whose data carries the start bit. An accepted request moves the track-and-hold into hold and raises BUSY. The conversion is anchored to the next master-clock falling edge and lasts a fixed half-integer number of master periods. One extra period is added when the start is flagged as having missed its setup window.

During the conversion the block presents a trial code to an external comparator, which is a stub outside this block. It keeps or drops each trial bit from the comparator decision, one bit per master period, MSB first. When BUSY falls, the resolved code is latched as the result and loaded into a 16-bit frame: two zero bits, then the 14 result bits MSB first. The frame leaves on a valid/ready serial stream, and the valid signal doubles as frame sync.

The stream rules are as follows. Valid stays high until all 16 bits have been taken, and one bit is taken on each clock where valid and ready are both high. While ready is low, the data bit and valid hold. A new result that arrives before the old frame has been fully taken replaces that frame. A two-period acquisition window follows every conversion, and the block returns to track during it.

Top module: `sar_conv_sequencer`

## Requirements
- R1: A synchronous active-high reset leaves busy, hold, acq, ser_valid, ser_data, mclk and result all at zero.
- R2: A conversion request is a rising edge of conv_start, or a clock with reg_wr high and reg_wdata bit 0 set. A write with bit 0 clear has no effect. The request is taken at the clock edge where it is seen, and busy rises after that edge.
- R3: mclk toggles on every clock after reset, starting from 0. Its falling edges are the odd-numbered edges (0, 1, 2, … counted from the first edge with reset low). The conversion anchor is the first such falling edge strictly after the acceptance edge.
- R4: busy falls 37 clocks after the anchor edge. If setup_miss was high at the acceptance edge, it falls 39 clocks after the anchor edge instead.
- R5: acq is high for exactly 4 clocks after busy falls, and busy and acq are never high together. Requests are ignored while busy or acq is high. The earliest new request is accepted at the edge where acq falls.
- R6: At anchor edges +2, +4, …, +28, the block keeps the current trial bit when cmp_bit is high. The trial code is the resolved bits so far plus a 1 at the next position, MSB first. When busy falls, result takes the resolved code, and result does not change at any other time.
- R7: The frame starts on the edge where busy falls. ser_valid stays high for the whole frame, the first two bits are 0, and the 14 result bits follow MSB first. ser_data is 0 whenever ser_valid is low.
- R8: A frame bit is consumed only on an edge where ser_valid and ser_ready are both high. While ser_ready is low, ser_data and ser_valid hold. A new result replaces an unfinished frame.
- R9: hold is high from the acceptance edge until busy falls, and the block is in track (hold low) at all other times, including during acq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Start pin, rising edge requests a conversion |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control write data, bit 0 is the start bit |
| setup_miss | input | 1 | Start missed its setup window (adds one period) |
| cmp_bit | input | 1 | Comparator decision for the current trial code |
| mclk | output | 1 | Master clock, half this clock's rate |
| busy | output | 1 | Conversion in progress |
| hold | output | 1 | Track-and-hold in hold |
| acq | output | 1 | Acquisition window active |
| dac_trial | output | 14 | Trial code presented to the comparator |
| result | output | 14 | Last completed conversion result |
| ser_valid | output | 1 | Frame sync, a frame bit is valid |
| ser_ready | input | 1 | Sink accepts a frame bit |
| ser_data | output | 1 | Serial frame bit |

## Verification
The assertions take every input as synchronous to clk. They treat ser_ready as a free level that may drop at any cycle, and they expect cmp_bit to respond only to the trial code presented. The stimulus changes every input on the falling clock edge. It derives cmp_bit by comparing a held input level against dac_trial, and it changes that level only while no conversion is running. The stimulus covers start requests on both mclk phases, requests during busy and acq, and a request held high across the acquisition boundary. It also varies the ready patterns so that stalls fall in the leading zeros, in the data bits and across a frame replacement.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_CONV = 2'd2,
    PH_ACQ  = 2'd3
  } phase_e;
endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int RES_W      = 14,
  parameter int CONV_HALF  = 37,
  parameter int MISS_EXTRA = 2,
  parameter int ACQ_HALF   = 4,
  parameter int CTRL_W     = 8,
  parameter int START_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              setup_miss,
  output logic              mclk,
  output logic              busy,
  output logic              hold,
  output logic              acq,
  output logic              conv_begin,
  output logic              capture,
  output logic              finish
);
  localparam int CNT_W = $clog2(CONV_HALF + MISS_EXTRA + 1);
  localparam int ACQ_W = $clog2(ACQ_HALF + 1);
  localparam logic [CNT_W-1:0] LAST_OK   = CNT_W'(CONV_HALF - 1);
  localparam logic [CNT_W-1:0] LAST_MISS = CNT_W'(CONV_HALF + MISS_EXTRA - 1);
  localparam logic [CNT_W-1:0] CAP_LIM   = CNT_W'(2 * RES_W);
  localparam logic [ACQ_W-1:0] ACQ_LAST  = ACQ_W'(ACQ_HALF - 1);

  phase_e           state;
  logic             mph;
  logic             start_q;
  logic             miss_q;
  logic [CNT_W-1:0] el;
  logic [ACQ_W-1:0] acq_cnt;
  logic             start_evt;

  assign start_evt  = (conv_start & ~start_q) | (reg_wr & reg_wdata[START_BIT]);
  assign conv_begin = (state == PH_WAIT) && mph;
  assign capture    = (state == PH_CONV) && el[0] && (el < CAP_LIM);
  assign finish     = (state == PH_CONV) && (el == (miss_q ? LAST_MISS : LAST_OK));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PH_IDLE;
      mph     <= 1'b0;
      start_q <= 1'b0;
      miss_q  <= 1'b0;
      el      <= '0;
      acq_cnt <= '0;
    end else begin
      mph     <= ~mph;
      start_q <= conv_start;
      unique case (state)
        PH_IDLE: if (start_evt) begin
          state  <= PH_WAIT;
          miss_q <= setup_miss;
        end
        PH_WAIT: if (mph) begin
          state <= PH_CONV;
          el    <= '0;
        end
        PH_CONV: if (finish) begin
          state   <= PH_ACQ;
          acq_cnt <= '0;
        end else begin
          el <= el + 1'b1;
        end
        PH_ACQ: if (acq_cnt == ACQ_LAST) begin
          if (start_evt) begin
            state  <= PH_WAIT;
            miss_q <= setup_miss;
          end else begin
            state <= PH_IDLE;
          end
        end else begin
          acq_cnt <= acq_cnt + 1'b1;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign mclk = mph;
  assign busy = (state == PH_WAIT) || (state == PH_CONV);
  assign hold = busy;
  assign acq  = (state == PH_ACQ);

  p_acq_follows_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> acq);
  p_busy_acq_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(busy && acq));
  p_mclk_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (mclk != $past(mclk)));
  p_busy_ends_in_acq_r4: assert property (@(posedge clk) disable iff (rst)
    finish |=> (acq && !busy));
endmodule

// File: rtl/sar_seq_resolve.sv
module sar_seq_resolve #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_begin,
  input  logic             capture,
  input  logic             finish,
  input  logic             cmp_bit,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] code,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] TOP_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sar;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] probe;

  assign probe = TOP_ONE >> idx;
  assign trial = sar | probe;
  assign code  = sar;

  always_ff @(posedge clk) begin
    if (rst) begin
      sar    <= '0;
      idx    <= '0;
      result <= '0;
    end else begin
      if (conv_begin) begin
        sar <= '0;
        idx <= '0;
      end else if (capture) begin
        if (cmp_bit) sar <= trial;
        idx <= idx + 1'b1;
      end
      if (finish) result <= sar;
    end
  end

  p_result_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(result));
endmodule

// File: rtl/sar_seq_frame.sv
module sar_seq_frame #(
  parameter int RES_W   = 14,
  parameter int FRAME_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] load_data,
  input  logic             ready,
  output logic             valid,
  output logic             sdata
);
  localparam int FC_W = $clog2(FRAME_W);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [FC_W-1:0]    fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      fcnt  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      shreg <= FRAME_W'(load_data);
      fcnt  <= '0;
      valid <= 1'b1;
    end else if (valid && ready) begin
      if (fcnt == FC_LAST) begin
        valid <= 1'b0;
        shreg <= '0;
      end else begin
        shreg <= shreg << 1;
        fcnt  <= fcnt + 1'b1;
      end
    end
  end

  assign sdata = valid & shreg[FRAME_W-1];

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !load) |=> (valid && $stable(sdata)));
  p_lead_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> !sdata);
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer #(
  parameter int RES_W      = 14,
  parameter int FRAME_W    = 16,
  parameter int CONV_HALF  = 37,
  parameter int MISS_EXTRA = 2,
  parameter int ACQ_HALF   = 4,
  parameter int CTRL_W     = 8,
  parameter int START_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              setup_miss,
  input  logic              cmp_bit,
  output logic              mclk,
  output logic              busy,
  output logic              hold,
  output logic              acq,
  output logic [RES_W-1:0]  dac_trial,
  output logic [RES_W-1:0]  result,
  output logic              ser_valid,
  input  logic              ser_ready,
  output logic              ser_data
);
  logic             conv_begin;
  logic             capture;
  logic             finish;
  logic [RES_W-1:0] code;

  sar_seq_timer #(
    .RES_W(RES_W), .CONV_HALF(CONV_HALF), .MISS_EXTRA(MISS_EXTRA),
    .ACQ_HALF(ACQ_HALF), .CTRL_W(CTRL_W), .START_BIT(START_BIT)
  ) u_timer (
    .clk(clk), .rst(rst), .conv_start(conv_start), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .setup_miss(setup_miss), .mclk(mclk),
    .busy(busy), .hold(hold), .acq(acq), .conv_begin(conv_begin),
    .capture(capture), .finish(finish)
  );

  sar_seq_resolve #(.RES_W(RES_W)) u_resolve (
    .clk(clk), .rst(rst), .conv_begin(conv_begin), .capture(capture),
    .finish(finish), .cmp_bit(cmp_bit), .trial(dac_trial), .code(code),
    .result(result)
  );

  sar_seq_frame #(.RES_W(RES_W), .FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst), .load(finish), .load_data(code),
    .ready(ser_ready), .valid(ser_valid), .sdata(ser_data)
  );
endmodule

// File: tb/sar_conv_sequencer_bench.sv
module sar_conv_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_start = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        setup_miss = 1'b0;
  logic        cmp_bit;
  logic        mclk, busy, hold, acq, ser_valid, ser_data;
  logic        ser_ready = 1'b1;
  logic [13:0] dac_trial, result;
  logic [13:0] ain = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign cmp_bit = (ain >= dac_trial);

  sar_conv_sequencer u_sar_conv_sequencer (
    .clk(clk), .rst(rst), .conv_start(conv_start), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .setup_miss(setup_miss), .cmp_bit(cmp_bit),
    .mclk(mclk), .busy(busy), .hold(hold), .acq(acq), .dac_trial(dac_trial),
    .result(result), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_data(ser_data)
  );

  // Behavioural reference built on edge time stamps and a bit queue
  int k = 0;
  int acc_at = -100;
  int done_at = -100;
  int free_at = 0;
  int m_result = 0;
  int pend_val = 0;
  bit prev_start = 0;
  bit m_rst = 1;
  bit fq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_rst = 1; k = 0; acc_at = -100; done_at = -100; free_at = 0;
      m_result = 0; prev_start = 0; fq.delete();
    end else begin
      bit ev;
      m_rst = 0;
      ev = (conv_start && !prev_start) || (reg_wr && reg_wdata[0]);
      prev_start = conv_start;
      if (fq.size() > 0 && ser_ready) void'(fq.pop_front());
      if (k == done_at) begin
        m_result = pend_val;
        fq.delete();
        fq.push_back(0); fq.push_back(0);
        for (int i = 13; i >= 0; i--) fq.push_back(pend_val[i]);
      end
      if (ev && k >= free_at) begin
        int anc;
        acc_at = k;
        anc = (k % 2 == 1) ? k + 2 : k + 1;
        done_at = anc + (setup_miss ? 39 : 37);
        free_at = done_at + 4;
        pend_val = ain;
      end
      k++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (m_rst) begin
        // R1 reset state
        chk(busy == 0 && hold == 0 && acq == 0, "R1", {busy, hold, acq}, 0);
        chk(ser_valid == 0 && ser_data == 0, "R1", {ser_valid, ser_data}, 0);
        chk(mclk == 0 && result == 0, "R1", result, 0);
      end else begin
        int e;
        bit eb, ea, ev;
        int ed;
        e  = k - 1;
        eb = (acc_at <= e) && (e < done_at);
        ea = (done_at <= e) && (e < done_at + 4);
        ev = (fq.size() > 0);
        ed = ev ? fq[0] : 0;
        chk(mclk == k[0], "R3", mclk, k[0]);
        chk(busy == eb, "R4", busy, eb);
        chk(hold == eb, "R9", hold, eb);
        chk(acq == ea, "R5", acq, ea);
        chk(result == m_result[13:0], "R6", result, m_result);
        chk(ser_valid == ev, "R7", ser_valid, ev);
        chk(ser_data == ed[0], "R8", ser_data, ed);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    conv_start = 1'b1; tick(1); conv_start = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; tick(1); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R2/R3: start pulse on an even edge, mid-scale code, full ready
    ain = 14'h2A5B; tick(2);
    pulse_start();
    tick(80);
    // R2: write with start bit clear is ignored
    write_ctrl(8'hFE); tick(10);
    // R2/R4: register start on the other phase with setup miss, full scale
    ain = 14'h3FFF; setup_miss = 1'b1; tick(1);
    write_ctrl(8'h01); setup_miss = 1'b0;
    // R5: requests during busy are ignored
    tick(10); pulse_start(); tick(5); write_ctrl(8'h01);
    tick(60);
    // R8: stalls in leading zeros and data, code zero
    ain = 14'h0000; pulse_start();
    tick(40);
    for (int i = 0; i < 40; i++) begin
      ser_ready = (i % 3 == 0); tick(1);
    end
    ser_ready = 1'b1; tick(20);
    // R5: request held across the acquisition boundary, back to back
    ain = 14'h1234;
    reg_wr = 1'b1; reg_wdata = 8'h01; setup_miss = 1'b0;
    tick(90);
    reg_wr = 1'b0; reg_wdata = '0;
    tick(60);
    // R8: new result replaces an unfinished frame
    ain = 14'h0F0F; ser_ready = 1'b0; pulse_start(); tick(50);
    ain = 14'h3001; pulse_start(); tick(50);
    ser_ready = 1'b1; tick(30);
    // R6: alternating code, start on the odd phase
    ain = 14'h1555; tick(1); pulse_start(); tick(70);
    // R1: reset in the middle of a conversion
    pulse_start(); tick(12); rst = 1'b1; tick(3); rst = 1'b0; tick(5);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule